// File: doc/BRIEF.md
# Single-Bit RAM with Complementary Tri-State Outputs

This block is a 256-location memory, one bit wide, modelled around a single clock. A write is presented by holding the active-low select low and the write enable high. The block captures the data bit on the rising clock edge. With the select low and the write enable low, the block reads. The stored bit at the presented address appears combinationally on the true output. The complement output always carries the inverse value.

During a write cycle both outputs echo the incoming data bit, not the old contents. Raising the select floats both outputs through their enable flags and blocks every write. Several devices can therefore share one output wire when only one select is low at a time.

All pins are plain level controls. The block accepts a new read or write command in every clock cycle and never stalls a caller, so there is no valid/ready pairing and no back-pressure. The storage is static. Its contents are never cleared, not even by reset. Reset only holds the outputs floating and blocks writes while it is low.

Top module: `bitwide_ram`

## Requirements
- R1: The array holds 2^ADDR_W locations (256 by default), one bit each, selected by the binary value on `addr_i`. Every location keeps its own bit independently of the others.
- R2: While `cs_ni` is 1, `q_oe_o` and `qn_oe_o` are both 0, so two devices with exclusive selects never drive a shared wire together.
- R3: While `cs_ni` is 1, no location changes, whatever the levels of `we_i` and `din_i`.
- R4: When `rst_ni`=1, `cs_ni`=0 and `we_i`=1 at a rising clock edge, `din_i` is stored at `addr_i`. The new bit is readable from the next cycle on.
- R5: With `cs_ni`=0 and `we_i`=0, `q_o` equals the stored bit at the present `addr_i` in the same cycle, without a clock edge.
- R6: With `cs_ni`=0 and `we_i`=1, `q_o` equals `din_i` and `qn_o` equals its inverse in the same cycle.
- R7: Whenever the outputs are enabled, `qn_o` is the logical inverse of `q_o`.
- R8: `q_oe_o` and `qn_oe_o` are 1 exactly when `cs_ni`=0 and `rst_ni`=1.
- R9: While `rst_ni` is 0, writes are blocked and both outputs float. Contents written before reset are still present afterwards.
- R10: Contents persist unchanged through any number of idle or deselected cycles, without any refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes commit on its rising edge |
| rst_ni | input | 1 | Active-low reset; floats outputs and blocks writes, does not clear storage |
| cs_ni | input | 1 | Active-low chip select |
| we_i | input | 1 | Write enable, active high |
| addr_i | input | ADDR_W | Word address |
| din_i | input | 1 | Data bit to write |
| q_o | output | 1 | True data output value |
| q_oe_o | output | 1 | Drive enable of the true output |
| qn_o | output | 1 | Complement data output value |
| qn_oe_o | output | 1 | Drive enable of the complement output |

## Verification
The output values and enable flags respond in the same cycle as the inputs: zero cycles for read data, the write echo and the float. A write becomes visible through a read only in the cycle after the rising edge that stores it. The bench therefore drives all inputs on the falling edge and compares the outputs one nanosecond later against a behavioural reference model. The model's stored bits are updated only at the following rising edge, and only when the write condition held. A second instance shares the address and data pins, and the bench checks the wired output for the exclusive-select case.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  typedef enum logic [1:0] {
    BWR_OFF   = 2'd0,
    BWR_READ  = 2'd1,
    BWR_WRITE = 2'd2
  } bwr_mode_e;

  function automatic bwr_mode_e bwr_classify(input logic live, input logic sel_n, input logic wen);
    if (!live || sel_n) return BWR_OFF;
    if (wen)            return BWR_WRITE;
    return BWR_READ;
  endfunction

endpackage

// File: rtl/bwr_ctrl.sv
module bwr_ctrl
  import bwr_pkg::*;
(
  input  logic      rst_ni,
  input  logic      cs_ni,
  input  logic      we_i,
  output bwr_mode_e mode_o,
  output logic      commit_o
);

  always_comb begin
    mode_o   = bwr_classify(rst_ni, cs_ni, we_i);
    commit_o = (mode_o == BWR_WRITE);
  end

endmodule

// File: rtl/bwr_decode.sv
module bwr_decode #(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DEPTH-1:0]  sel_o
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign sel_o[g] = (addr_i == ADDR_W'(g));
  end

endmodule

// File: rtl/bwr_store.sv
module bwr_store #(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DEPTH-1:0]  sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              rd_o
);

  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_i && sel_i[i]) cells[i] <= din_i;
    end
  end

  assign rd_o = |(sel_i & cells);

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cells)); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cells[$past(addr_i)] == $past(din_i))); // R4

endmodule

// File: rtl/bwr_outmux.sv
module bwr_outmux
  import bwr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  bwr_mode_e mode_i,
  input  logic      din_i,
  input  logic      rd_i,
  output logic      q_o,
  output logic      q_oe_o,
  output logic      qn_o,
  output logic      qn_oe_o
);

  always_comb begin
    q_o     = 1'b0;
    qn_o    = 1'b0;
    q_oe_o  = 1'b0;
    qn_oe_o = 1'b0;
    case (mode_i)
      BWR_WRITE: begin
        q_o     = din_i;
        qn_o    = ~din_i;
        q_oe_o  = 1'b1;
        qn_oe_o = 1'b1;
      end
      BWR_READ: begin
        q_o     = rd_i;
        qn_o    = ~rd_i;
        q_oe_o  = 1'b1;
        qn_oe_o = 1'b1;
      end
      default: ;
    endcase
  end

  AST_FLOAT_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == BWR_OFF) |-> (!q_oe_o && !qn_oe_o)); // R2
  AST_ECHO_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == BWR_WRITE) |-> (q_o == din_i && qn_o == !din_i)); // R6
  AST_READ_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == BWR_READ) |-> (q_o == rd_i)); // R5

endmodule

// File: rtl/bitwide_ram.sv
module bitwide_ram
  import bwr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              q_o,
  output logic              q_oe_o,
  output logic              qn_o,
  output logic              qn_oe_o
);

  localparam int DEPTH = 1 << ADDR_W;

  bwr_mode_e        mode;
  logic             commit;
  logic [DEPTH-1:0] sel;
  logic             rd_bit;

  bwr_ctrl u_ctrl (
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .we_i     (we_i),
    .mode_o   (mode),
    .commit_o (commit)
  );

  bwr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  bwr_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (commit),
    .sel_i  (sel),
    .addr_i (addr_i),
    .din_i  (din_i),
    .rd_o   (rd_bit)
  );

  bwr_outmux u_outmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .din_i   (din_i),
    .rd_i    (rd_bit),
    .q_o     (q_o),
    .q_oe_o  (q_oe_o),
    .qn_o    (qn_o),
    .qn_oe_o (qn_oe_o)
  );

  AST_DESELECT_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!q_oe_o && !qn_oe_o)); // R2
  AST_COMPLEMENT_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_oe_o && qn_oe_o) |-> (qn_o != q_o)); // R7
  AST_ENABLE_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_oe_o || qn_oe_o) |-> !cs_ni); // R8
  AST_SELECTED_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |-> (q_oe_o && qn_oe_o)); // R8

endmodule

// File: tb/bitwide_ram_tb.sv
module bitwide_ram_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       csa_n = 1'b1;
  logic       csb_n = 1'b1;
  logic       we    = 1'b0;
  logic [7:0] addr  = '0;
  logic       din   = 1'b0;
  logic       qa, qa_oe, qna, qna_oe;
  logic       qb, qb_oe, qnb, qnb_oe;
  logic       bus;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 1'b0;

  bit  ref_a [256];
  bit  ref_b [256];
  bit  known_a [256];
  bit  known_b [256];

  bitwide_ram #(.ADDR_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(csa_n), .we_i(we), .addr_i(addr), .din_i(din),
    .q_o(qa), .q_oe_o(qa_oe), .qn_o(qna), .qn_oe_o(qna_oe)
  );

  bitwide_ram #(.ADDR_W(8)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(csb_n), .we_i(we), .addr_i(addr), .din_i(din),
    .q_o(qb), .q_oe_o(qb_oe), .qn_o(qnb), .qn_oe_o(qnb_oe)
  );

  // wired-OR of the two tri-state true outputs
  assign bus = (qa_oe & qa) | (qb_oe & qb);

  function automatic bit pat(input logic [7:0] a);
    return a[0] ^ a[3] ^ a[7] ^ (a[2] & a[5]);
  endfunction

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %b expected %b (addr %0d)", req, what, got, exp, addr);
    end
  endtask

  task automatic step(input logic r, input logic ca, input logic cb, input logic w,
                      input logic [7:0] a, input logic d, input string req);
    logic ea, eb, xa, xb;
    @(negedge clk);
    rst_n = r; csa_n = ca; csb_n = cb; we = w; addr = a; din = d;
    #1;
    ea = r && !ca;
    eb = r && !cb;
    chk(req, "A q_oe", qa_oe, ea);
    chk(req, "A qn_oe", qna_oe, ea);
    chk(req, "B q_oe", qb_oe, eb);
    chk(req, "B qn_oe", qnb_oe, eb);
    xa = w ? d : ref_a[a];
    xb = w ? d : ref_b[a];
    if (ea && (w || known_a[a])) begin
      chk(req, "A q", qa, xa);
      chk(req, "A qn", qna, ~xa);
    end
    if (eb && (w || known_b[a])) begin
      chk(req, "B q", qb, xb);
      chk(req, "B qn", qnb, ~xb);
    end
    if (ea && eb) chk("R2", "two drivers on bus", 1'b1, 1'b0);
    if (ea && !eb && (w || known_a[a])) chk(req, "bus from A", bus, xa);
    if (eb && !ea && (w || known_b[a])) chk(req, "bus from B", bus, xb);
    @(posedge clk);
    if (r && !ca && w) begin ref_a[a] = d; known_a[a] = 1'b1; end
    if (r && !cb && w) begin ref_b[a] = d; known_b[a] = 1'b1; end
  endtask

  initial begin
    // R9 R8: reset holds outputs floating and blocks writes even if selected
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 8'(i), 1'b1, "R9");
    // R1 R4 R6: fill every location of A; B deselected (R2 R3)
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 8'(i), pat(8'(i)), "R6");
    // R1 R5 R7: read back every location of A
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 8'(i), 1'b0, "R1");
    // R5: read with a different address every cycle, descending order
    for (int i = 255; i >= 0; i -= 7) step(1'b1, 1'b0, 1'b1, 1'b0, 8'(i), 1'b1, "R5");
    // R3: deselected write attempts with inverted data must not land
    for (int i = 0; i < 32; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'(i * 5), ~pat(8'(i * 5)), "R3");
    for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 8'(i * 5), 1'b0, "R3");
    // R10: long idle while deselected, then read
    for (int i = 0; i < 150; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 8'(i), 1'b0, "R10");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 8'(i * 3 + 1), 1'b0, "R10");
    // R9: reset with selected write attempts; contents survive
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 8'(i * 11), ~pat(8'(i * 11)), "R9");
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 8'(i * 11), 1'b0, "R9");
    // R4: overwrite then immediate read on the next cycle
    for (int i = 0; i < 24; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'(200 + i), ~pat(8'(200 + i)), "R4");
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'(200 + i), 1'b0, "R4");
    end
    // R7: write-through with both data values on one address
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'd77, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'd77, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b0, 8'd77, 1'b0, "R7");
    // R2: fill B with inverted pattern while A deselected, then share the bus
    for (int i = 0; i < 64; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 8'(i), ~pat(8'(i)), "R2");
    for (int i = 0; i < 64; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'(i), 1'b0, "R2");
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'(i), 1'b0, "R2");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule